// File: doc/BRIEF.md
# Object-Identifier-Addressed Attribute Store

This block holds the attribute words of every object in a small object-based system. Objects are named by a 12-bit identifier made of a 4-bit class number (upper bits) and an 8-bit object number that is unique within that class. There are no raw memory addresses at the interface. Hardware method units and the processor share the one access port as a single global data store.

Each class has a fixed object capacity and a fixed attribute count. Both are set by parameters. At elaboration the block lays out one contiguous region per class, class 0 lowest, and sizes the storage to the sum of the regions. An allocation request hands out the next free object number of the requested class. An access request carries an identifier, an attribute index, a write flag and write data. The block checks the identifier against the allocation state and checks the index against the class attribute count. It then maps the access to base(class) + object × attributes(class) + index, and either writes the word or returns it one cycle later.

The reset input is asynchronous and active low, and its release is synchronised inside the block. Reset clears the allocation counters. Storage contents are not cleared.

Top module: `oid_mem`

## Requirements
- R1: After reset, `alloc_ok`, `alloc_fail`, `acc_ack` and `acc_err` are low. Every class counter is zero, so the first allocation in any class returns object number 0.
- R2: An allocation request for a valid class that is not full raises `alloc_ok` one cycle later, with `alloc_oid` = {class[3:0], object[7:0]}. Object numbers come out 0, 1, 2, … in order, and each class counts separately.
- R3: An allocation request for a class that already holds its maximum number of objects raises `alloc_fail` one cycle later. The counter does not move, so later requests to that class fail too, and other classes are unaffected.
- R4: A class number at or above the configured number of classes is rejected. An allocation gets `alloc_fail`, and an access gets `acc_err` with no write.
- R5: A read that passes the checks raises `acc_ack` one cycle later, with `acc_rdata` holding the word at base(class) + object × attributes(class) + index. Every valid (class, object, index) triple maps to its own distinct word.
- R6: A write that passes the checks stores the word in the cycle it is presented and raises `acc_ack` one cycle later. A read of the same word in the very next cycle returns the new value.
- R7: An access whose object number is not yet allocated in its class raises `acc_err` one cycle later and writes nothing.
- R8: An access whose attribute index is not less than the class attribute count raises `acc_err` one cycle later and writes nothing, including to the neighbouring object's words.
- R9: When an allocation and an access fall in the same cycle, the access is judged against the allocation count from before that cycle. An access to the object number being handed out in that same cycle therefore fails.
- R10: `acc_ack` and `acc_err` are never high together. Exactly one of them follows each access request by one cycle, and neither is raised without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Request a new object |
| alloc_cid | input | 4 | Class of the object to create |
| alloc_ok | output | 1 | Allocation succeeded (one cycle after the request) |
| alloc_fail | output | 1 | Class full or class number invalid |
| alloc_oid | output | 12 | Identifier given out: {class, object number} |
| acc_req | input | 1 | Attribute access request |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_oid | input | 12 | Target identifier {class, object number} |
| acc_idx | input | 8 | Attribute index within the object |
| acc_wdata | input | DATA_W | Data to write |
| acc_ack | output | 1 | Access accepted (one cycle after the request) |
| acc_err | output | 1 | Access rejected, nothing written |
| acc_rdata | output | DATA_W | Read data, valid with `acc_ack` after a read |

## Verification
Creating an object and accessing an attribute can fall in the same cycle. The interesting case is an access to exactly the object number that the allocation is handing out. The bench provokes this by raising both requests on one edge for the same class. It expects `acc_err` together with `alloc_ok`, and then expects the same read to succeed on the following cycle. It also pairs an allocation with an access to an object that already exists, and expects both to succeed. All other checks are exhaustive sweeps over a four-class configuration, with each class's capacity and attribute count chosen to differ. The bench computes every word address and data pattern arithmetically.

// File: rtl/oid_mem_pkg.sv
package oid_mem_pkg;

  localparam int CID_W  = 4;
  localparam int OBJN_W = 8;
  localparam int OID_W  = CID_W + OBJN_W;
  localparam int FLD_W  = 8;
  localparam int MAX_CLS = 16;

  typedef struct packed {
    logic [CID_W-1:0]  cid;
    logic [OBJN_W-1:0] objn;
  } oid_t;

  // Sum of capacity x attribute count over classes [0, upto).
  function automatic int unsigned region_sum(
    input logic [MAX_CLS*FLD_W-1:0] cap_v,
    input logic [MAX_CLS*FLD_W-1:0] att_v,
    input int                       upto
  );
    int unsigned s;
    s = 0;
    for (int k = 0; k < upto; k++) begin
      s += int'(cap_v[k*FLD_W +: FLD_W]) * int'(att_v[k*FLD_W +: FLD_W]);
    end
    return s;
  endfunction

endpackage

// File: rtl/oid_alloc.sv
module oid_alloc
  import oid_mem_pkg::*;
#(
  parameter int                     NCLS    = 4,
  parameter int                     CNT_W   = OBJN_W + 1,
  parameter logic [NCLS*FLD_W-1:0]  CAP_VEC = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic [CID_W-1:0]      cid,
  output logic                  ok_q,
  output logic                  fail_q,
  output oid_t                  oid_q,
  output logic [NCLS*CNT_W-1:0] cnt_flat
);

  logic [CNT_W-1:0] cnt_q [NCLS];
  logic [CNT_W-1:0] cnt_d [NCLS];
  logic             ok_d;
  logic             fail_d;
  oid_t             oid_d;

  // next-state
  always_comb begin
    logic hit;
    hit    = 1'b0;
    ok_d   = 1'b0;
    fail_d = 1'b0;
    oid_d  = oid_q;
    for (int c = 0; c < NCLS; c++) begin
      cnt_d[c] = cnt_q[c];
    end
    if (req) begin
      for (int c = 0; c < NCLS; c++) begin
        if (cid == CID_W'(c)) begin
          hit = 1'b1;
          if (cnt_q[c] < CNT_W'(CAP_VEC[c*FLD_W +: FLD_W])) begin
            ok_d       = 1'b1;
            oid_d.cid  = cid;
            oid_d.objn = cnt_q[c][OBJN_W-1:0];
            cnt_d[c]   = cnt_q[c] + CNT_W'(1);
          end else begin
            fail_d = 1'b1;
          end
        end
      end
      if (!hit) begin
        fail_d = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCLS; c++) begin
        cnt_q[c] <= '0;
      end
      ok_q   <= 1'b0;
      fail_q <= 1'b0;
      oid_q  <= '0;
    end else begin
      for (int c = 0; c < NCLS; c++) begin
        cnt_q[c] <= cnt_d[c];
      end
      ok_q   <= ok_d;
      fail_q <= fail_d;
      if (req) begin
        oid_q <= oid_d;
      end
    end
  end

  for (genvar g = 0; g < NCLS; g++) begin : g_cnt
    localparam logic [CNT_W-1:0] CAPG = CNT_W'(CAP_VEC[g*FLD_W +: FLD_W]);

    assign cnt_flat[g*CNT_W +: CNT_W] = cnt_q[g];

    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q[g] <= CAPG);

    a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      (req && cid == CID_W'(g) && cnt_q[g] < CAPG)
        |=> (ok_q && cnt_q[g] == $past(cnt_q[g]) + CNT_W'(1)));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (req && cid == CID_W'(g) && cnt_q[g] == CAPG)
        |=> (fail_q && $stable(cnt_q[g])));
  end

endmodule

// File: rtl/oid_xlate.sv
module oid_xlate
  import oid_mem_pkg::*;
#(
  parameter int                    NCLS     = 4,
  parameter int                    CNT_W    = OBJN_W + 1,
  parameter int                    IDX_W    = 8,
  parameter int                    AW       = 5,
  parameter int                    DEPTH    = 31,
  parameter logic [NCLS*FLD_W-1:0] CAP_VEC  = '0,
  parameter logic [NCLS*FLD_W-1:0] ATTR_VEC = '0
) (
  input  oid_t                  oid,
  input  logic [IDX_W-1:0]      idx,
  input  logic [NCLS*CNT_W-1:0] cnt_flat,
  output logic                  legal,
  output logic [AW-1:0]         addr
);

  logic [AW-1:0]    base_tab [NCLS];
  logic [FLD_W-1:0] attr_tab [NCLS];

  for (genvar g = 0; g < NCLS; g++) begin : g_tab
    localparam int unsigned BASE_G =
      region_sum((MAX_CLS*FLD_W)'(CAP_VEC), (MAX_CLS*FLD_W)'(ATTR_VEC), g);
    assign base_tab[g] = AW'(BASE_G);
    assign attr_tab[g] = ATTR_VEC[g*FLD_W +: FLD_W];
  end

  always_comb begin
    legal = 1'b0;
    addr  = '0;
    for (int c = 0; c < NCLS; c++) begin
      if (oid.cid == CID_W'(c)) begin
        if ((CNT_W'(oid.objn) < cnt_flat[c*CNT_W +: CNT_W]) &&
            (int'(idx) < int'(attr_tab[c]))) begin
          legal = 1'b1;
        end
        addr = base_tab[c] + AW'(oid.objn) * AW'(attr_tab[c]) + AW'(idx);
      end
    end
  end

  // R5: a legal access must land inside the storage
  always_comb begin
    if (legal === 1'b1) begin
      a_r5_addr_in_range: assert (int'(addr) < DEPTH);
    end
  end

endmodule

// File: rtl/oid_store.sv
module oid_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 31,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata_q
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && int'(waddr) < DEPTH) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (re && int'(raddr) < DEPTH) begin
      rdata_q <= mem[raddr];
    end
  end

endmodule

// File: rtl/oid_mem.sv
module oid_mem
  import oid_mem_pkg::*;
#(
  parameter int                           NUM_CLASSES  = 4,
  parameter int                           DATA_W       = 16,
  parameter int                           IDX_W        = 8,
  parameter logic [NUM_CLASSES*FLD_W-1:0] CLS_CAP      = {8'd5, 8'd2, 8'd3, 8'd4},
  parameter logic [NUM_CLASSES*FLD_W-1:0] CLS_ATTR_CNT = {8'd1, 8'd4, 8'd2, 8'd3}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_req,
  input  logic [3:0]        alloc_cid,
  output logic              alloc_ok,
  output logic              alloc_fail,
  output logic [11:0]       alloc_oid,
  input  logic              acc_req,
  input  logic              acc_we,
  input  logic [11:0]       acc_oid,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              acc_ack,
  output logic              acc_err,
  output logic [DATA_W-1:0] acc_rdata
);

  localparam int CNT_W = OBJN_W + 1;
  localparam int DEPTH_RAW = int'(region_sum((MAX_CLS*FLD_W)'(CLS_CAP),
                                             (MAX_CLS*FLD_W)'(CLS_ATTR_CNT),
                                             NUM_CLASSES));
  localparam int DEPTH = (DEPTH_RAW > 0) ? DEPTH_RAW : 1;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // reset: asserted asynchronously, released on the clock
  logic rst_s1_q;
  logic rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q  <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_s1_q  <= 1'b1;
      rst_int_n <= rst_s1_q;
    end
  end

  logic [NUM_CLASSES*CNT_W-1:0] cnt_flat;
  oid_t                         new_oid;
  logic                         legal;
  logic [AW-1:0]                addr;
  logic                         mem_we;
  logic                         mem_re;
  logic                         ack_d;
  logic                         err_d;
  logic                         ack_q;
  logic                         err_q;

  oid_alloc #(
    .NCLS    (NUM_CLASSES),
    .CNT_W   (CNT_W),
    .CAP_VEC (CLS_CAP)
  ) u_alloc (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .req      (alloc_req),
    .cid      (alloc_cid),
    .ok_q     (alloc_ok),
    .fail_q   (alloc_fail),
    .oid_q    (new_oid),
    .cnt_flat (cnt_flat)
  );

  assign alloc_oid = new_oid;

  oid_xlate #(
    .NCLS     (NUM_CLASSES),
    .CNT_W    (CNT_W),
    .IDX_W    (IDX_W),
    .AW       (AW),
    .DEPTH    (DEPTH),
    .CAP_VEC  (CLS_CAP),
    .ATTR_VEC (CLS_ATTR_CNT)
  ) u_xlate (
    .oid      (oid_t'(acc_oid)),
    .idx      (acc_idx),
    .cnt_flat (cnt_flat),
    .legal    (legal),
    .addr     (addr)
  );

  // next-state for the access response
  always_comb begin
    mem_we = acc_req && acc_we && legal;
    mem_re = acc_req && !acc_we && legal;
    ack_d  = acc_req && legal;
    err_d  = acc_req && !legal;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ack_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      ack_q <= ack_d;
      err_q <= err_d;
    end
  end

  oid_store #(
    .DW    (DATA_W),
    .DEPTH (DEPTH),
    .AW    (AW)
  ) u_store (
    .clk     (clk),
    .we      (mem_we),
    .waddr   (addr),
    .wdata   (acc_wdata),
    .re      (mem_re),
    .raddr   (addr),
    .rdata_q (acc_rdata)
  );

  assign acc_ack = ack_q;
  assign acc_err = err_q;

  a_r10_resp_excl: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(acc_ack && acc_err));

  a_r10_resp_follows: assert property (@(posedge clk) disable iff (!rst_int_n)
    acc_req |=> (acc_ack || acc_err));

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_int_n)
    !acc_req |=> !(acc_ack || acc_err));

  a_r2_alloc_excl: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(alloc_ok && alloc_fail));

  a_r4_bad_class: assert property (@(posedge clk) disable iff (!rst_int_n)
    (alloc_req && int'(alloc_cid) >= NUM_CLASSES) |=> alloc_fail);

endmodule

// File: tb/oid_mem_tb.sv
module oid_mem_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NCLS = 4;
  localparam int DW   = 16;

  int cap_t  [NCLS] = '{4, 3, 2, 5};
  int attr_t [NCLS] = '{3, 2, 4, 1};

  logic          clk = 1'b0;
  logic          rst_n;
  logic          alloc_req;
  logic [3:0]    alloc_cid;
  logic          alloc_ok;
  logic          alloc_fail;
  logic [11:0]   alloc_oid;
  logic          acc_req;
  logic          acc_we;
  logic [11:0]   acc_oid;
  logic [7:0]    acc_idx;
  logic [DW-1:0] acc_wdata;
  logic          acc_ack;
  logic          acc_err;
  logic [DW-1:0] acc_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oid_mem #(
    .NUM_CLASSES  (NCLS),
    .DATA_W       (DW),
    .IDX_W        (8),
    .CLS_CAP      ({8'd5, 8'd2, 8'd3, 8'd4}),
    .CLS_ATTR_CNT ({8'd1, 8'd4, 8'd2, 8'd3})
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_req  (alloc_req),
    .alloc_cid  (alloc_cid),
    .alloc_ok   (alloc_ok),
    .alloc_fail (alloc_fail),
    .alloc_oid  (alloc_oid),
    .acc_req    (acc_req),
    .acc_we     (acc_we),
    .acc_oid    (acc_oid),
    .acc_idx    (acc_idx),
    .acc_wdata  (acc_wdata),
    .acc_ack    (acc_ack),
    .acc_err    (acc_err),
    .acc_rdata  (acc_rdata)
  );

  function automatic logic [DW-1:0] pat(input int c, input int o, input int i);
    return DW'(32'hA000 + c*256 + o*16 + i);
  endfunction

  task automatic check(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_alloc(input int c, input bit exp_ok, input int exp_objn, input string req);
    alloc_req = 1'b1;
    alloc_cid = 4'(c);
    @(negedge clk);
    alloc_req = 1'b0;
    check(alloc_ok === exp_ok && alloc_fail === !exp_ok, req,
          int'({alloc_ok, alloc_fail}), int'({exp_ok, !exp_ok}));
    if (exp_ok) begin
      check(alloc_oid === {4'(c), 8'(exp_objn)}, req, int'(alloc_oid),
            int'({4'(c), 8'(exp_objn)}));
    end
  endtask

  task automatic do_acc(input bit we, input int c, input int o, input int i,
                        input logic [DW-1:0] wd, input bit exp_ok,
                        input logic [DW-1:0] exp_d, input string req);
    acc_req   = 1'b1;
    acc_we    = we;
    acc_oid   = {4'(c), 8'(o)};
    acc_idx   = 8'(i);
    acc_wdata = wd;
    @(negedge clk);
    acc_req = 1'b0;
    check(acc_ack === exp_ok && acc_err === !exp_ok, req,
          int'({acc_ack, acc_err}), int'({exp_ok, !exp_ok}));
    if (exp_ok && !we) begin
      check(acc_rdata === exp_d, req, int'(acc_rdata), int'(exp_d));
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    alloc_req = 1'b0; alloc_cid = '0;
    acc_req = 1'b0; acc_we = 1'b0; acc_oid = '0; acc_idx = '0; acc_wdata = '0;
    @(negedge clk);
    do_reset();

    // R1: idle outputs after reset
    check(alloc_ok === 1'b0 && alloc_fail === 1'b0 && acc_ack === 1'b0 && acc_err === 1'b0,
          "R1", int'({alloc_ok, alloc_fail, acc_ack, acc_err}), 0);

    // R2/R3: fill each class, counting from 0; then overflow twice
    for (int c = 0; c < NCLS; c++) begin
      for (int o = 0; o < cap_t[c]; o++) begin
        do_alloc(c, 1'b1, o, "R2");
      end
      do_alloc(c, 1'b0, 0, "R3");
      do_alloc(c, 1'b0, 0, "R3");
    end

    // R4: class numbers beyond the configuration
    do_alloc(4, 1'b0, 0, "R4");
    do_alloc(15, 1'b0, 0, "R4");
    do_acc(1'b0, 5, 0, 0, '0, 1'b0, '0, "R4");
    do_acc(1'b1, 15, 0, 0, 16'h1234, 1'b0, '0, "R4");

    // R5: exhaustive write, then exhaustive read of distinct patterns
    for (int c = 0; c < NCLS; c++)
      for (int o = 0; o < cap_t[c]; o++)
        for (int i = 0; i < attr_t[c]; i++)
          do_acc(1'b1, c, o, i, pat(c, o, i), 1'b1, '0, "R5");
    for (int c = 0; c < NCLS; c++)
      for (int o = 0; o < cap_t[c]; o++)
        for (int i = 0; i < attr_t[c]; i++)
          do_acc(1'b0, c, o, i, '0, 1'b1, pat(c, o, i), "R5");

    // R6: write immediately followed by read of the same word
    for (int c = 0; c < NCLS; c++) begin
      do_acc(1'b1, c, 1, 0, 16'h5A00 + 16'(c), 1'b1, '0, "R6");
      do_acc(1'b0, c, 1, 0, '0, 1'b1, 16'h5A00 + 16'(c), "R6");
      do_acc(1'b1, c, 1, 0, pat(c, 1, 0), 1'b1, '0, "R6");
    end

    // R8: index at and beyond the attribute count; neighbour untouched
    for (int c = 0; c < NCLS; c++) begin
      do_acc(1'b1, c, 0, attr_t[c], 16'hDEAD, 1'b0, '0, "R8");
      do_acc(1'b1, c, 0, 255, 16'hBEEF, 1'b0, '0, "R8");
      do_acc(1'b0, c, 0, attr_t[c], '0, 1'b0, '0, "R8");
      do_acc(1'b0, c, 1, 0, '0, 1'b1, pat(c, 1, 0), "R8");
    end

    // R7: after reset nothing is allocated; storage keeps its contents
    do_reset();
    do_acc(1'b0, 0, 0, 0, '0, 1'b0, '0, "R7");
    do_acc(1'b1, 0, 0, 0, 16'h0BAD, 1'b0, '0, "R7");
    do_acc(1'b1, 2, 1, 3, 16'h0BAD, 1'b0, '0, "R7");
    do_alloc(0, 1'b1, 0, "R1");
    do_acc(1'b0, 0, 0, 0, '0, 1'b1, pat(0, 0, 0), "R7");
    do_acc(1'b1, 0, 1, 0, 16'h0BAD, 1'b0, '0, "R7");
    do_alloc(0, 1'b1, 1, "R2");
    do_acc(1'b0, 0, 1, 0, '0, 1'b1, pat(0, 1, 0), "R7");

    // R9: allocation and access in the same cycle
    alloc_req = 1'b1; alloc_cid = 4'd1;
    acc_req = 1'b1; acc_we = 1'b0; acc_oid = {4'd1, 8'd0}; acc_idx = 8'd1;
    @(negedge clk);
    alloc_req = 1'b0; acc_req = 1'b0;
    check(acc_err === 1'b1 && acc_ack === 1'b0, "R9",
          int'({acc_ack, acc_err}), 1);
    check(alloc_ok === 1'b1 && alloc_oid === 12'h100, "R9", int'(alloc_oid), 12'h100);
    do_acc(1'b0, 1, 0, 1, '0, 1'b1, pat(1, 0, 1), "R9");
    alloc_req = 1'b1; alloc_cid = 4'd0;
    acc_req = 1'b1; acc_we = 1'b0; acc_oid = {4'd0, 8'd1}; acc_idx = 8'd2;
    @(negedge clk);
    alloc_req = 1'b0; acc_req = 1'b0;
    check(acc_ack === 1'b1 && acc_rdata === pat(0, 1, 2), "R9",
          int'(acc_rdata), int'(pat(0, 1, 2)));
    check(alloc_ok === 1'b1 && alloc_oid === 12'h002, "R9", int'(alloc_oid), 12'h002);

    // R10: idle cycle gives no response
    @(negedge clk);
    check(acc_ack === 1'b0 && acc_err === 1'b0, "R10",
          int'({acc_ack, acc_err}), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule